// File: doc/BRIEF.md
# Four-Wire Serial Register Port Master

This block talks to the register port of a peripheral over four wires: an active-low select, a serial clock, a data line toward the peripheral and a data line back from it. A host pulses a command with a read/write flag, a register index and, for writes, a data byte. The block then produces the serial frames and reports completion with a one-cycle done strobe; for reads it also returns the byte it fetched.

Each bit takes three equal timing units, each `DIV` system clocks long. The serial clock falls, the outgoing bit is placed on the data line one unit later, and the clock rises for the third unit, so the peripheral latches on the rising edge. Data moves most significant bit first. A write is one select frame. A read is two frames: the first loads the peripheral's register pointer, and the second carries the read-flagged address and then clocks the reply in. The peripheral address is a parameter, `DEV_ADDR`, with 0x20 as its default.

Top module: `ctlport_master`

## Requirements
- R1: After reset and whenever the block is idle, select and serial clock are high, and busy and done are low.
- R2: A write command produces one frame of 24 clock pulses carrying, in order, `DEV_ADDR` with bit 0 forced to 0, the register index, and the data byte, each most significant bit first, sampled on the rising serial clock.
- R3: Each bit spends one unit with the clock low and the data unchanged, one unit with the clock low and the new bit driven, and one unit with the clock high. A unit is `DIV` system clocks. A write therefore raises done exactly 73·`DIV` clocks after the accepting edge.
- R4: After the last clock pulse of any frame, select rises, and the frame counts as ended. Between the two frames of a read, select stays high for exactly one unit.
- R5: The first frame of a read has 16 clock pulses carrying `DEV_ADDR` with bit 0 cleared, then the register index.
- R6: The second frame of a read has 16 clock pulses. The first 8 carry `DEV_ADDR` with bit 0 set. During the last 8, the return line is sampled at the end of the first low unit of each bit, and the outgoing line holds its last driven level (1).
- R7: The first sampled return bit ends up in bit 7 of `rdData`. `rdData` is valid when done pulses, and done for a read comes 98·`DIV` clocks after the accepting edge.
- R8: Busy rises on the clock after a command is accepted and falls when done is raised. A command presented while busy is ignored and causes no frame.
- R9: Done is high for exactly one clock per command.
- R10: With the default parameters, the address bytes on the wire are 0x20 for writes and pointer loads, and 0x21 for read fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken only when idle |
| cmdRead | input | 1 | 1 = register read, 0 = register write |
| cmdMap | input | 8 | Register index |
| cmdData | input | 8 | Write data byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte returned by the last read |
| csN | output | 1 | Active-low select to the peripheral |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
A wrong phase or bit counter shows up in the pulse count of the next frame that select closes, and in the number of clocks between command acceptance and done. Both are visible within one command. A frame-type error, such as a skipped pointer frame or a write sent as a read, changes the address byte or frame length at once. A bad capture path appears as a wrong `rdData` on the done pulse of the affected read. A faulty idle check shows up as an extra frame that the scoreboard has not queued.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  // Which byte the datapath loads into its transmit shifter
  typedef enum logic [1:0] {SEL_ADDR_WR, SEL_ADDR_RD, SEL_MAP, SEL_DATA} byteSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchCmd;
    logic     loadByte;
    byteSel_e sel;
    logic     putBit;
    logic     shiftOut;
    logic     takeBit;
    logic     capture;
  } dpStrobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_SET, ST_HIGH, ST_GAP} phase_e;
  typedef enum logic [1:0] {FR_WRITE, FR_POINT, FR_FETCH} frame_e;
endpackage

// File: rtl/ctlport_ctrl.sv
module ctlport_ctrl
  import ctlport_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdValid,
  input  logic      cmdRead,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      csN,
  output logic      sclk
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  phase_e        state;
  frame_e        frame;
  logic [CW-1:0] tickCnt;
  logic [2:0]    bitCnt;
  logic [1:0]    byteIdx;
  logic          unitDone;
  logic          lastByte;
  logic          readingByte;
  logic          lastBit;

  assign unitDone    = (tickCnt == CW'(DIV - 1));
  assign lastByte    = (frame == FR_WRITE) ? (byteIdx == 2'd2) : (byteIdx == 2'd1);
  assign readingByte = (frame == FR_FETCH) && (byteIdx == 2'd1);
  assign lastBit     = (bitCnt == 3'd7);
  assign busy        = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    strobe.sel = SEL_MAP;
    case (state)
      ST_IDLE: if (cmdValid) begin
        strobe.latchCmd = 1'b1;
        strobe.loadByte = 1'b1;
        strobe.sel      = SEL_ADDR_WR;
      end
      ST_LOW: if (unitDone) begin
        strobe.takeBit = readingByte;
        strobe.putBit  = !readingByte;
      end
      ST_HIGH: if (unitDone) begin
        strobe.shiftOut = 1'b1;
        if (lastBit && !lastByte) begin
          strobe.loadByte = 1'b1;
          strobe.sel      = (byteIdx == 2'd0) ? SEL_MAP : SEL_DATA;
        end
      end
      ST_GAP: if (unitDone) begin
        if (frame == FR_POINT) begin
          strobe.loadByte = 1'b1;
          strobe.sel      = SEL_ADDR_RD;
        end else begin
          strobe.capture = (frame == FR_FETCH);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      frame   <= FR_WRITE;
      tickCnt <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) tickCnt <= unitDone ? '0 : tickCnt + 1'b1;
      case (state)
        ST_IDLE: if (cmdValid) begin
          frame   <= cmdRead ? FR_POINT : FR_WRITE;
          csN     <= 1'b0;
          sclk    <= 1'b0;
          bitCnt  <= '0;
          byteIdx <= '0;
          tickCnt <= '0;
          state   <= ST_LOW;
        end
        ST_LOW: if (unitDone) state <= ST_SET;
        ST_SET: if (unitDone) begin
          sclk  <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: if (unitDone) begin
          if (lastBit) begin
            bitCnt <= '0;
            if (lastByte) begin
              csN   <= 1'b1;
              state <= ST_GAP;
            end else begin
              byteIdx <= byteIdx + 1'b1;
              sclk    <= 1'b0;
              state   <= ST_LOW;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
            sclk   <= 1'b0;
            state  <= ST_LOW;
          end
        end
        ST_GAP: if (unitDone) begin
          if (frame == FR_POINT) begin
            frame   <= FR_FETCH;
            byteIdx <= '0;
            csN     <= 1'b0;
            sclk    <= 1'b0;
            state   <= ST_LOW;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctlport_dp.sv
module ctlport_dp
  import ctlport_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  dpStrobe_t strobe,
  input  logic [7:0] cmdMap,
  input  logic [7:0] cmdData,
  input  logic      miso,
  output logic      mosi,
  output logic [7:0] rdData
);
  logic [7:0] mapReg;
  logic [7:0] dataReg;
  logic [7:0] txSh;
  logic [7:0] rxSh;
  logic [7:0] nextByte;

  always_comb begin
    case (strobe.sel)
      SEL_ADDR_WR: nextByte = {DEV_ADDR[7:1], 1'b0};
      SEL_ADDR_RD: nextByte = {DEV_ADDR[7:1], 1'b1};
      SEL_MAP:     nextByte = mapReg;
      default:     nextByte = dataReg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapReg  <= '0;
      dataReg <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      mosi    <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.latchCmd) begin
        mapReg  <= cmdMap;
        dataReg <= cmdData;
      end
      if (strobe.loadByte)      txSh <= nextByte;
      else if (strobe.shiftOut) txSh <= {txSh[6:0], 1'b0};
      if (strobe.putBit)  mosi   <= txSh[7];
      if (strobe.takeBit) rxSh   <= {rxSh[6:0], miso};
      if (strobe.capture) rdData <= rxSh;
    end
  end
endmodule

// File: rtl/ctlport_master.sv
module ctlport_master
  import ctlport_pkg::*;
#(
  parameter int         DIV      = 4,
  parameter logic [7:0] DEV_ADDR = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic       cmdRead,
  input  logic [7:0] cmdMap,
  input  logic [7:0] cmdData,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       csN,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  dpStrobe_t strobe;

  ctlport_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .strobe(strobe), .busy(busy), .done(done), .csN(csN), .sclk(sclk)
  );

  ctlport_dp #(.DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdMap(cmdMap),
    .cmdData(cmdData), .miso(miso), .mosi(mosi), .rdData(rdData)
  );
endmodule

// File: rtl/ctlport_master_chk.sv
module ctlport_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic csN,
  input logic sclk
);
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csN && sclk));

  p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !csN);

  p_cs_rise_clock_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csN) |-> sclk);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmdValid) |=> busy);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ctlport_master ctlport_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .busy(busy),
  .done(done), .csN(csN), .sclk(sclk)
);

// File: tb/ctlport_master_tb.sv
`timescale 1ns/1ps
module ctlport_master_tb;
  localparam int UNIT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdRead = 1'b0;
  logic [7:0] cmdMap = '0;
  logic [7:0] cmdData = '0;
  logic       busy, done, csN, sclk, mosi, miso;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          nbits;
    logic [23:0] value;
    int          kind;   // 0 write (R2), 1 pointer (R5), 2 fetch (R6)
  } frame_t;
  frame_t expQ[$];

  ctlport_master #(.DIV(UNIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdMap(cmdMap), .cmdData(cmdData), .busy(busy), .done(done),
    .rdData(rdData), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Peripheral model and monitor
  logic        inFrame = 1'b0;
  int          frmBits = 0;
  logic [23:0] frmSh = '0;
  logic [7:0]  reply = '0;
  bit          gapPending = 0;
  realtime     riseT = 0;

  assign miso = (inFrame && frmBits >= 8 && frmBits < 16) ? reply[3'(15 - frmBits)] : 1'b0;

  always @(negedge csN) if (rst_n) begin
    if (gapPending) begin
      gapPending = 0;
      check(($realtime - riseT) == UNIT * 20.0, "R4 gap between read frames",
            int'(($realtime - riseT) / 20.0), UNIT);
    end
    inFrame = 1'b1;
    frmBits = 0;
    frmSh   = '0;
  end

  always @(posedge sclk) if (inFrame && !csN) begin
    frmSh   = {frmSh[22:0], mosi};
    frmBits = frmBits + 1;
  end

  always @(posedge csN) if (inFrame) begin
    frame_t e;
    string  tag;
    inFrame = 1'b0;
    riseT   = $realtime;
    if (expQ.size() == 0) begin
      check(0, "R8 unexpected frame", frmBits, 0);
    end else begin
      e = expQ.pop_front();
      tag = (e.kind == 0) ? "R2 write frame" : (e.kind == 1) ? "R5 pointer frame" : "R6 fetch frame";
      check(frmBits == e.nbits, {tag, " pulses"}, frmBits, e.nbits);
      check(frmSh == e.value, {tag, " bits"}, int'(frmSh), int'(e.value));
      if (e.kind == 1) gapPending = 1;
    end
  end

  // Driver: queues expectations, issues command, measures latency
  task automatic runCmd(input bit rd, input logic [7:0] map, input logic [7:0] dat,
                        input logic [7:0] rep, input bit poke);
    frame_t f;
    int cnt;
    int expCnt;
    if (rd) begin
      f.nbits = 16; f.value = {8'h00, 8'h20, map}; f.kind = 1; expQ.push_back(f);
      f.nbits = 16; f.value = {8'h00, 8'h21, 8'hFF}; f.kind = 2; expQ.push_back(f);
      expCnt = 98 * UNIT;
    end else begin
      f.nbits = 24; f.value = {8'h20, map, dat}; f.kind = 0; expQ.push_back(f);
      expCnt = 73 * UNIT;
    end
    reply = rep;
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = rd; cmdMap = map; cmdData = dat;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    cnt = 0;
    while (!done) begin
      cnt++;
      if (poke && cnt == 10) begin
        cmdValid = 1'b1; cmdRead = 1'b0; cmdMap = 8'hEE; cmdData = 8'h11;
      end
      if (poke && cnt == 12) cmdValid = 1'b0;
      @(negedge clk);
    end
    check(cnt == expCnt, rd ? "R7 read latency" : "R3 write latency", cnt, expCnt);
    check(busy == 1'b0, "R8 busy low at done", busy, 0);
    if (rd) check(rdData == rep, "R7 read data", rdData, rep);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", done, 0);
    check(csN && sclk && !busy, "R1 idle levels after command", {csN, sclk, busy}, 3'b110);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b1, "R1 reset levels", {csN, sclk}, 2'b11);
    check(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    runCmd(0, 8'h04, 8'h80, 8'h00, 0);   // R2 R10
    runCmd(0, 8'h05, 8'h05, 8'h00, 0);
    runCmd(0, 8'hA5, 8'h3C, 8'h00, 1);   // R8 ignored command
    runCmd(1, 8'h7F, 8'h00, 8'hB4, 0);   // R5 R6 R7
    runCmd(1, 8'h00, 8'h00, 8'h01, 0);
    runCmd(1, 8'h26, 8'h00, 8'h80, 1);   // R8 during read
    runCmd(0, 8'hFF, 8'h00, 8'h00, 0);
    repeat (5 * UNIT) @(negedge clk);
    check(expQ.size() == 0, "R8 all frames seen", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule